// File: doc/BRIEF.md
# Triggered Waveform Playback Sequencer

This block paces the playback of waveform samples that sit in an external sample FIFO. A loadable interval counter divides a timebase tick into update slots. In each slot the block raises a one-cycle read request toward the FIFO and drives an active-low DAC update strobe. The strobe is low for one tick, and the converter latches data on its falling edge. Playback is organised in passes. A pass is a programmed number of updates. Passes repeat a programmed number of times, or without end when the repeat count is zero. An optional gap of idle ticks can separate one pass from the next.

A start trigger launches playback. In post-trigger mode playback begins at once. In delay-trigger mode it begins after a programmed number of ticks. With retrigger enabled, the block waits for a fresh start trigger before each further pass. A stop trigger ends playback in one of three ways: at once, at the end of the current pass, or at the end of the current pass and its gap. A one-cycle done pulse marks every return to idle. When the update count is shorter than the stored waveform, each pass plays only part of it, and the output is built piece by piece.

Top module: `wfseq_top`

## Requirements
- R1: After reset, `upd_n` is 1 and `rd_req` and `done` are 0. Without a start trigger, no request is issued. A stop trigger while idle produces no `done`.
- R2: In post-trigger mode (`trig_mode`=0), with `tick` held high, the first `rd_req` appears two clock cycles after the cycle in which `start_trig` is sampled. `upd_n` is 0 in every cycle in which `rd_req` is 1.
- R3: Consecutive updates within a pass are spaced by the effective interval: `ivl_cfg`, or 40 ticks when `ivl_cfg` is below 40.
- R4: Each strobe stays low until the next tick and then returns high, including after playback has ended.
- R5: In delay-trigger mode (`trig_mode`=1), the first update comes `start_dly` ticks later than in post-trigger mode. A `start_dly` of 0 behaves as post-trigger.
- R6: With `iter_cnt` N>0 and `upd_cnt` U>0, exactly U*N updates are issued. `done` then pulses in the same cycle as the last `rd_req`.
- R7: With `iter_cnt`=0, playback continues without a `done` until a stop trigger arrives.
- R8: With `gap_len` G>0, the first update of a following pass comes G+1 ticks after the last update of the previous pass. With G=0, it comes one effective interval later.
- R9: With `retrig_en`=1, after each pass that is not the last, the block issues no update until a new `start_trig` arrives. That trigger starts the next pass with the same latency as in R2.
- R10: `stop_mode`=0 (and also 3) ends playback at once: no further update, and `done` one cycle after the stop is sampled.
- R11: `stop_mode`=1 lets the running pass complete and then ends with no gap. `done` coincides with the last update.
- R12: `stop_mode`=2 lets the running pass and its gap complete. `done` comes G ticks after the last update.
- R13: `done` is high for exactly one cycle per return to idle.
- R14: A `start_trig` while playing is ignored when `retrig_en`=0. The update count and spacing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one tick per high cycle |
| start_trig | input | 1 | Start trigger |
| stop_trig | input | 1 | Stop trigger |
| retrig_en | input | 1 | Wait for a new start before each further pass |
| trig_mode | input | 1 | 0 post-trigger, 1 delay-trigger |
| stop_mode | input | 2 | 0 immediate, 1 end of pass, 2 end of pass and gap, 3 immediate |
| ivl_cfg | input | 16 | Update interval in ticks (minimum 40 applied) |
| upd_cnt | input | 16 | Updates per pass |
| iter_cnt | input | 16 | Pass count, 0 for endless |
| start_dly | input | 16 | Start delay in ticks |
| gap_len | input | 16 | Gap between passes in ticks |
| upd_n | output | 1 | Active-low DAC update strobe |
| rd_req | output | 1 | One-cycle sample read request |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
The hardest states to reach from the ports are the deferred stops. For these, the stop has to land inside a pass, not on its last update, and the gap that follows has to be long enough to tell the two deferred modes apart. The stimulus counts the requests as they arrive and raises the stop right after a chosen mid-pass update. The resulting update totals and the timing of `done` then separate the three stop behaviours. A run with a random tick pattern checks that each strobe rises only on a tick. Random configurations with a fixed seed, some with intervals below the floor, exercise the spacing and the gaps between passes.

// File: rtl/wfseq_pkg.sv
package wfseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RUN,
        ST_GAP,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        STOP_NOW  = 2'd0,
        STOP_PASS = 2'd1,
        STOP_GAP  = 2'd2,
        STOP_ALT  = 2'd3
    } stop_mode_e;

endpackage

// File: rtl/wfseq_pacer.sv
module wfseq_pacer #(
    parameter int IVL_W   = 16,
    parameter int MIN_IVL = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [IVL_W-1:0] ivl_cfg,
    output logic             fire,
    output logic             upd_n,
    output logic             rd_req
);
    localparam logic [IVL_W-1:0] FLOOR = IVL_W'(MIN_IVL);

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic             upd_n;
        logic             rd_req;
    } pacer_s;

    pacer_s pc_d, pc_q;
    logic [IVL_W-1:0] eff_ivl;

    assign eff_ivl = (ivl_cfg < FLOOR) ? FLOOR : ivl_cfg;
    assign fire    = run && tick && (pc_q.ivl == '0);

    always_comb begin
        pc_d        = pc_q;
        pc_d.rd_req = fire;
        if (restart) begin
            pc_d.ivl = '0;
        end else if (fire) begin
            pc_d.ivl = eff_ivl - 1'b1;
        end else if (run && tick && (pc_q.ivl != '0)) begin
            pc_d.ivl = pc_q.ivl - 1'b1;
        end
        if (fire) begin
            pc_d.upd_n = 1'b0;
        end else if (tick) begin
            pc_d.upd_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '{ivl: '0, upd_n: 1'b1, rd_req: 1'b0};
        end else begin
            pc_q <= pc_d;
        end
    end

    assign upd_n  = pc_q.upd_n;
    assign rd_req = pc_q.rd_req;

    // spacing monitor: ticks seen since the previous update
    logic [IVL_W-1:0] since_q;
    logic             armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else begin
            if (restart) begin
                armed_q <= 1'b0;
            end else if (fire) begin
                armed_q <= 1'b1;
            end
            if (fire) begin
                since_q <= '0;
            end else if (tick && (since_q != '1)) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    p_ivl_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && armed_q |-> since_q >= IVL_W'(MIN_IVL - 1));

    p_strobe_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !upd_n);

    p_strobe_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_n && tick && !fire |=> upd_n);

endmodule

// File: rtl/wfseq_ctrl.sv
module wfseq_ctrl
    import wfseq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ITER_W = 16,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              retrig_en,
    input  logic              trig_mode,
    input  logic [1:0]        stop_mode,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [ITER_W-1:0] iter_cnt,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic [DLY_W-1:0]  gap_len,
    input  logic              fire,
    output logic              run,
    output logic              restart,
    output logic              done
);
    typedef struct packed {
        seq_state_e        st;
        logic [DLY_W-1:0]  dly;
        logic [CNT_W-1:0]  ucnt;
        logic [ITER_W-1:0] iter;
        logic              pend;
        logic              done;
    } ctrl_s;

    ctrl_s      cs_d, cs_q;
    stop_mode_e sm;
    logic       imm_stop;
    logic       kill;

    assign sm = stop_mode_e'(stop_mode);

    always_comb begin
        case (sm)
            STOP_PASS: imm_stop = (cs_q.st != ST_RUN);
            STOP_GAP:  imm_stop = (cs_q.st == ST_DELAY) || (cs_q.st == ST_WAIT);
            default:   imm_stop = 1'b1;
        endcase
    end

    assign kill = stop_trig && (cs_q.st != ST_IDLE) && imm_stop;
    assign run  = (cs_q.st == ST_RUN) && !kill;

    logic             pend_now;
    logic             final_iter;
    logic [CNT_W-1:0] last_upd;

    always_comb begin
        pend_now   = cs_q.pend || (stop_trig && (cs_q.st != ST_IDLE));
        final_iter = (iter_cnt != '0) &&
                     (({1'b0, cs_q.iter} + 1'b1) >= {1'b0, iter_cnt});
        last_upd   = (upd_cnt == '0) ? '0 : upd_cnt - 1'b1;

        cs_d      = cs_q;
        cs_d.done = 1'b0;

        case (cs_q.st)
            ST_IDLE: begin
                if (start_trig) begin
                    cs_d.iter = '0;
                    cs_d.ucnt = '0;
                    cs_d.pend = 1'b0;
                    if (trig_mode && (start_dly != '0)) begin
                        cs_d.st  = ST_DELAY;
                        cs_d.dly = start_dly;
                    end else begin
                        cs_d.st = ST_RUN;
                    end
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    if (cs_q.dly <= DLY_W'(1)) begin
                        cs_d.st = ST_RUN;
                    end else begin
                        cs_d.dly = cs_q.dly - 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (fire) begin
                    if (cs_q.ucnt >= last_upd) begin
                        cs_d.ucnt = '0;
                        cs_d.iter = cs_q.iter + 1'b1;
                        if (final_iter || (pend_now && (sm == STOP_PASS))) begin
                            cs_d.st = ST_IDLE;
                        end else if (gap_len != '0) begin
                            cs_d.st  = ST_GAP;
                            cs_d.dly = gap_len;
                        end else if (pend_now) begin
                            cs_d.st = ST_IDLE;
                        end else if (retrig_en) begin
                            cs_d.st = ST_WAIT;
                        end
                    end else begin
                        cs_d.ucnt = cs_q.ucnt + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (cs_q.dly <= DLY_W'(1)) begin
                        if (pend_now) begin
                            cs_d.st = ST_IDLE;
                        end else if (retrig_en) begin
                            cs_d.st = ST_WAIT;
                        end else begin
                            cs_d.st = ST_RUN;
                        end
                    end else begin
                        cs_d.dly = cs_q.dly - 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (start_trig) begin
                    if (trig_mode && (start_dly != '0)) begin
                        cs_d.st  = ST_DELAY;
                        cs_d.dly = start_dly;
                    end else begin
                        cs_d.st = ST_RUN;
                    end
                end
            end
            default: cs_d.st = ST_IDLE;
        endcase

        if (stop_trig && (cs_q.st != ST_IDLE)) begin
            cs_d.pend = 1'b1;
        end
        if (kill) begin
            cs_d.st = ST_IDLE;
        end
        cs_d.done = (cs_q.st != ST_IDLE) && (cs_d.st == ST_IDLE);
        restart   = (cs_d.st == ST_RUN) && (cs_q.st != ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{st: ST_IDLE, dly: '0, ucnt: '0, iter: '0, pend: 1'b0, done: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign done = cs_q.done;

    p_fire_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> cs_q.st == ST_RUN);

    p_ucnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.st == ST_RUN) && (upd_cnt != '0) |-> cs_q.ucnt < upd_cnt);

    p_stop_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_trig && (stop_mode == 2'd0) && (cs_q.st != ST_IDLE) |=> (cs_q.st == ST_IDLE) && cs_q.done);

    p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.done |=> !cs_q.done);

endmodule

// File: rtl/wfseq_top.sv
module wfseq_top #(
    parameter int IVL_W   = 16,
    parameter int CNT_W   = 16,
    parameter int ITER_W  = 16,
    parameter int DLY_W   = 16,
    parameter int MIN_IVL = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              retrig_en,
    input  logic              trig_mode,
    input  logic [1:0]        stop_mode,
    input  logic [IVL_W-1:0]  ivl_cfg,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [ITER_W-1:0] iter_cnt,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic [DLY_W-1:0]  gap_len,
    output logic              upd_n,
    output logic              rd_req,
    output logic              done
);
    logic fire;
    logic run;
    logic restart;

    wfseq_ctrl #(
        .CNT_W (CNT_W),
        .ITER_W(ITER_W),
        .DLY_W (DLY_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_trig(start_trig),
        .stop_trig (stop_trig),
        .retrig_en (retrig_en),
        .trig_mode (trig_mode),
        .stop_mode (stop_mode),
        .upd_cnt   (upd_cnt),
        .iter_cnt  (iter_cnt),
        .start_dly (start_dly),
        .gap_len   (gap_len),
        .fire      (fire),
        .run       (run),
        .restart   (restart),
        .done      (done)
    );

    wfseq_pacer #(
        .IVL_W  (IVL_W),
        .MIN_IVL(MIN_IVL)
    ) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run),
        .restart(restart),
        .ivl_cfg(ivl_cfg),
        .fire   (fire),
        .upd_n  (upd_n),
        .rd_req (rd_req)
    );

    p_rd_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !upd_n);

endmodule

// File: tb/wfseq_top_test.sv
module wfseq_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        start_trig;
    logic        stop_trig;
    logic        retrig_en;
    logic        trig_mode;
    logic [1:0]  stop_mode;
    logic [15:0] ivl_cfg;
    logic [15:0] upd_cnt;
    logic [15:0] iter_cnt;
    logic [15:0] start_dly;
    logic [15:0] gap_len;
    logic        upd_n;
    logic        rd_req;
    logic        done;

    int checks = 0;
    int errors = 0;
    int st_t [0:511];
    int n;
    int done_t;
    int done_cnt;

    always #4 clk = ~clk;

    wfseq_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_trig(start_trig),
        .stop_trig(stop_trig), .retrig_en(retrig_en), .trig_mode(trig_mode),
        .stop_mode(stop_mode), .ivl_cfg(ivl_cfg), .upd_cnt(upd_cnt),
        .iter_cnt(iter_cnt), .start_dly(start_dly), .gap_len(gap_len),
        .upd_n(upd_n), .rd_req(rd_req), .done(done)
    );

    function automatic int eff_ivl(int ivl);
        return (ivl < 40) ? 40 : ivl;
    endfunction

    function automatic int exp_space(int i, int upp, int ivl, int g);
        if ((i % upp) == 0 && g > 0) return g + 1;
        return eff_ivl(ivl);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_spacing(string req, int upp, int ivl, int g);
        int bad_i;
        int bad_a;
        int bad_e;
        bad_i = -1;
        bad_a = 0;
        bad_e = 0;
        for (int i = 1; i < n && i < 512; i++) begin
            if (bad_i < 0 && (st_t[i] - st_t[i-1]) != exp_space(i, upp, ivl, g)) begin
                bad_i = i;
                bad_a = st_t[i] - st_t[i-1];
                bad_e = exp_space(i, upp, ivl, g);
            end
        end
        chk(bad_i < 0, req, bad_a, bad_e);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_trig = 1'b1;
    endtask

    task automatic collect(int stop_at, int start_at, int max_cyc, bit rnd_tick);
        int  t;
        bit  prev_low;
        bit  prev_tick;
        t         = 0;
        n         = 0;
        done_t    = -1;
        done_cnt  = 0;
        prev_low  = 1'b0;
        prev_tick = tick;
        for (int c = 0; c < max_cyc; c++) begin
            @(negedge clk);
            t++;
            start_trig = 1'b0;
            stop_trig  = 1'b0;
            if (prev_low && !rd_req) begin
                // R4: a low strobe returns high on the first tick only
                chk(upd_n == prev_tick, "R4", int'(upd_n), int'(prev_tick));
            end
            if (rd_req) begin
                if (n < 512) st_t[n] = t;
                n++;
                chk(!upd_n, "R2", int'(upd_n), 0);
                if (n == stop_at) stop_trig = 1'b1;
                if (n == start_at) start_trig = 1'b1;
            end
            if (done) begin
                done_cnt++;
                if (done_t < 0) done_t = t;
            end
            prev_low = !upd_n;
            tick = rnd_tick ? 1'($urandom % 2) : 1'b1;
            prev_tick = tick;
            if (done_t >= 0 && t > done_t + 3) break;
        end
        tick = 1'b1;
    endtask

    task automatic setup(int ivl, int upp, int it, int dly, int g, bit mode, bit rt, int sm);
        @(negedge clk);
        ivl_cfg   = 16'(ivl);
        upd_cnt   = 16'(upp);
        iter_cnt  = 16'(it);
        start_dly = 16'(dly);
        gap_len   = 16'(g);
        trig_mode = mode;
        retrig_en = rt;
        stop_mode = 2'(sm);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_init;
        int r_ivl;
        int r_upp;
        int r_it;
        int r_g;
        seed_init = $urandom(32'd1729);
        rst_n = 1'b0; tick = 1'b1; start_trig = 1'b0; stop_trig = 1'b0;
        retrig_en = 1'b0; trig_mode = 1'b0; stop_mode = 2'd0;
        ivl_cfg = 16'd40; upd_cnt = 16'd1; iter_cnt = 16'd1;
        start_dly = 16'd0; gap_len = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle stop ignored
        @(negedge clk);
        chk(upd_n == 1'b1, "R1", int'(upd_n), 1);
        chk(rd_req == 1'b0, "R1", int'(rd_req), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        stop_trig = 1'b1;
        collect(0, 0, 20, 1'b0);
        chk(n == 0, "R1", n, 0);
        chk(done_cnt == 0, "R1", done_cnt, 0);

        // R2 R6: post-trigger finite run
        setup(50, 3, 2, 0, 0, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 0, 2000, 1'b0);
        chk(st_t[0] == 2, "R2", st_t[0], 2);
        chk(n == 6, "R6", n, 6);
        chk_spacing("R3", 3, 50, 0);
        chk(done_t == st_t[n-1], "R6", done_t, st_t[n-1]);
        chk(done_cnt == 1, "R13", done_cnt, 1);

        // R3: interval floor
        setup(5, 4, 1, 0, 0, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 0, 2000, 1'b0);
        chk(n == 4, "R3", n, 4);
        chk_spacing("R3", 4, 5, 0);

        // R5: delay trigger, and zero delay
        setup(40, 2, 1, 7, 0, 1'b1, 1'b0, 0);
        pulse_start();
        collect(0, 0, 2000, 1'b0);
        chk(st_t[0] == 9, "R5", st_t[0], 9);
        chk(n == 2, "R5", n, 2);
        setup(40, 2, 1, 0, 0, 1'b1, 1'b0, 0);
        pulse_start();
        collect(0, 0, 2000, 1'b0);
        chk(st_t[0] == 2, "R5", st_t[0], 2);

        // R8: gap between passes
        setup(45, 2, 3, 0, 10, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 0, 2000, 1'b0);
        chk(n == 6, "R8", n, 6);
        chk_spacing("R8", 2, 45, 10);

        // R14: start while playing ignored
        setup(40, 3, 2, 0, 0, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 2, 2000, 1'b0);
        chk(n == 6, "R14", n, 6);
        chk_spacing("R14", 3, 40, 0);

        // R9: retrigger waits for a start before each pass
        setup(40, 3, 3, 0, 0, 1'b0, 1'b1, 0);
        pulse_start();
        collect(0, 0, 300, 1'b0);
        chk(n == 3, "R9", n, 3);
        chk(done_cnt == 0, "R9", done_cnt, 0);
        pulse_start();
        collect(0, 0, 300, 1'b0);
        chk(n == 3, "R9", n, 3);
        chk(st_t[0] == 2, "R9", st_t[0], 2);
        pulse_start();
        collect(0, 0, 300, 1'b0);
        chk(n == 3 && done_t == st_t[2], "R9", done_t, st_t[2]);

        // R7: endless run, then stopped
        setup(40, 2, 0, 0, 0, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 0, 800, 1'b0);
        chk(n == 20, "R7", n, 20);
        chk(done_cnt == 0, "R7", done_cnt, 0);
        @(negedge clk);
        stop_trig = 1'b1;
        collect(0, 0, 10, 1'b0);
        chk(done_cnt == 1, "R7", done_cnt, 1);

        // R10: immediate stop
        setup(40, 4, 0, 0, 0, 1'b0, 1'b0, 0);
        pulse_start();
        collect(5, 0, 2000, 1'b0);
        chk(n == 5, "R10", n, 5);
        chk(done_t == st_t[4] + 1, "R10", done_t, st_t[4] + 1);

        // R11: stop at end of pass
        setup(40, 4, 0, 0, 12, 1'b0, 1'b0, 1);
        pulse_start();
        collect(5, 0, 2000, 1'b0);
        chk(n == 8, "R11", n, 8);
        chk(done_t == st_t[7], "R11", done_t, st_t[7]);
        chk_spacing("R11", 4, 40, 12);

        // R12: stop at end of pass and gap
        setup(40, 4, 0, 0, 12, 1'b0, 1'b0, 2);
        pulse_start();
        collect(5, 0, 2000, 1'b0);
        chk(n == 8, "R12", n, 8);
        chk(done_t == st_t[7] + 12, "R12", done_t, st_t[7] + 12);

        // R4: random tick pattern
        setup(40, 2, 2, 0, 3, 1'b0, 1'b0, 0);
        pulse_start();
        collect(0, 0, 3000, 1'b1);
        chk(n == 4, "R4", n, 4);
        chk(done_cnt == 1, "R13", done_cnt, 1);

        // random configurations: R3 R6 R8
        for (int k = 0; k < 6; k++) begin
            r_ivl = 1 + int'($urandom % 80);
            r_upp = 1 + int'($urandom % 4);
            r_it  = 1 + int'($urandom % 3);
            r_g   = int'($urandom % 15);
            setup(r_ivl, r_upp, r_it, 0, r_g, 1'b0, 1'b0, 0);
            pulse_start();
            collect(0, 0, 4000, 1'b0);
            chk(n == r_upp * r_it, "R6", n, r_upp * r_it);
            chk_spacing("R8", r_upp, r_ivl, r_g);
            chk(done_t == st_t[n-1], "R6", done_t, st_t[n-1]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule